// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block watches the fault flags of a PWM power stage and decides whether the gate driver may run. Faults fall into two classes. Dangerous conditions (supply overvoltage together with a saturated feedback, overtemperature, a shorted secondary, or an external latch request) force a latched-off state. Only a power-down reset leaves that state. Recoverable conditions (supply undervoltage, or overload that lasts beyond the blanking window) force an auto-restart state. The next startup cycle leaves that state and runs the converter again.

Every flag passes through a two-flop synchroniser. Glitch-prone sources then pass through hold filters of different lengths. Overload blanking has two stages. A fixed internal timer runs first. When it expires, the block releases the clamp on the blanking pin. Auto-restart is taken only after the pin voltage flag has stayed high for a further filter time. The external latch request is ignored for a startup window after each entry into running.

Top module: `prot_supervisor`

## Requirements
- R1: Out of reset the block is waiting for startup: gate_off_o=1, latched_o=0, autorst_o=0, bl_release_o=0.
- R2: In the waiting state, vcc_on_i high starts the run state, and gate_off_o goes low within a few cycles.
- R3: Overvoltage counts only while ovp_i and fb_high_i are both high for LONG_FILT consecutive synchronised cycles. ovp_i alone never latches.
- R4: otp_i must be high for LONG_FILT consecutive cycles to latch. A shorter pulse is ignored.
- R5: short_i must be high for SHORT_FILT consecutive cycles to latch. A single-cycle pulse is ignored.
- R6: ext_latch_i is ignored during the first INHIBIT cycles of the run state. After that window it latches off after synchronisation only.
- R7: The latched-off state holds the gate off and ignores vcc_on_i and uvlo_i. It clears only on pdr_i, which returns the block to the waiting state.
- R8: In the run state, fb_high_i with softstart_done_i high for BLANK cycles raises bl_release_o. While soft start runs, the timer does not advance.
- R9: After release, bl_thr_i must be high for LONG_FILT cycles before auto-restart is entered. A shorter pulse is ignored.
- R10: uvlo_i in the run state enters auto-restart directly.
- R11: Auto-restart holds the gate off until vcc_on_i, then starts a new run state.
- R12: When a latching fault and a recoverable fault arrive in the same cycle, latched-off wins.
- R13: latched_o and autorst_o are never both high, and either one forces gate_off_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdr_i | input | 1 | Supply below the power-down reset level |
| vcc_on_i | input | 1 | Supply above the turn-on level |
| uvlo_i | input | 1 | Supply below the turn-off level |
| softstart_done_i | input | 1 | Soft start period finished |
| ovp_i | input | 1 | Supply above the overvoltage level |
| fb_high_i | input | 1 | Feedback above the overload level |
| otp_i | input | 1 | Die overtemperature |
| short_i | input | 1 | Current sense above the short-winding level |
| ext_latch_i | input | 1 | Blanking pin pulled near ground |
| bl_thr_i | input | 1 | Blanking pin above its trip level |
| gate_off_o | output | 1 | Forces the gate driver low |
| latched_o | output | 1 | Latched-off state |
| autorst_o | output | 1 | Auto-restart state |
| bl_release_o | output | 1 | Opens the blanking-pin clamp switch |

## Verification
On every cycle, the assertions check that the two status outputs are exclusive and force the gate off. They also check that latched-off holds without a power-down reset, that a latching request in the run state beats any recoverable one, and that each filter or timer output follows a qualifying input. Whether pulses just shorter than a filter are rejected, whether the external request is really ignored during the startup window, and whether the overload timer stays frozen during soft start can only be shown by the bench's timed scenarios. The same holds for the full restart sequence from auto-restart back to running.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_AUTO  = 2'd2,
        ST_LATCH = 2'd3
    } prot_state_e;

    typedef struct packed {
        logic pdr;
        logic vcc_on;
        logic uvlo;
        logic ssd;
        logic ovp;
        logic fbh;
        logic otp;
        logic shrt;
        logic ext;
        logic blthr;
    } prot_flags_t;

    localparam int FLAG_W = $bits(prot_flags_t);

    function automatic logic gate_allowed(prot_state_e st);
        return st == ST_RUN;
    endfunction

endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            dout <= '0;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/prot_hold.sv
module prot_hold #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !din) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dout = (cnt == TOP);

    // Serves R4, R5, R6, R8 and R9: an expired filter or timer implies its input was high
    assert_hold_input_R4: assert property (@(posedge clk) disable iff (rst)
        dout |-> $past(din));
endmodule

// File: rtl/prot_fsm.sv
module prot_fsm
    import prot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pdr,
    input  logic        vcc_on,
    input  logic        latch_req,
    input  logic        auto_req,
    output prot_state_e state
);
    prot_state_e nxt;

    always_comb begin
        nxt = state;
        if (pdr) begin
            nxt = ST_WAIT;
        end else begin
            unique case (state)
                ST_WAIT:  if (vcc_on) nxt = ST_RUN;
                ST_RUN: begin
                    if (latch_req)     nxt = ST_LATCH;
                    else if (auto_req) nxt = ST_AUTO;
                end
                ST_AUTO:  if (vcc_on) nxt = ST_RUN;
                ST_LATCH: nxt = ST_LATCH;
                default:  nxt = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= nxt;
    end

    assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && !pdr) |=> state == ST_LATCH);

    assert_latch_priority_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && latch_req && !pdr) |=> state == ST_LATCH);
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import prot_pkg::*;
#(
    parameter int LONG_FILT  = 8,
    parameter int SHORT_FILT = 3,
    parameter int BLANK      = 200,
    parameter int INHIBIT    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic pdr_i,
    input  logic vcc_on_i,
    input  logic uvlo_i,
    input  logic softstart_done_i,
    input  logic ovp_i,
    input  logic fb_high_i,
    input  logic otp_i,
    input  logic short_i,
    input  logic ext_latch_i,
    input  logic bl_thr_i,
    output logic gate_off_o,
    output logic latched_o,
    output logic autorst_o,
    output logic bl_release_o
);
    prot_flags_t raw, s;
    prot_state_e state;
    logic        run;
    logic        ovp_ok, otp_ok, shrt_ok, bl_ok, armed;
    logic        latch_req, auto_req;

    assign raw = '{pdr: pdr_i, vcc_on: vcc_on_i, uvlo: uvlo_i, ssd: softstart_done_i,
                   ovp: ovp_i, fbh: fb_high_i, otp: otp_i, shrt: short_i,
                   ext: ext_latch_i, blthr: bl_thr_i};

    prot_sync #(.W(FLAG_W)) u_sync (.clk(clk), .rst(rst), .din(raw), .dout(s));

    assign run = (state == ST_RUN);

    prot_hold #(.LEN(LONG_FILT))  u_ovp  (.clk(clk), .rst(rst), .din(s.ovp & s.fbh), .dout(ovp_ok));
    prot_hold #(.LEN(LONG_FILT))  u_otp  (.clk(clk), .rst(rst), .din(s.otp), .dout(otp_ok));
    prot_hold #(.LEN(SHORT_FILT)) u_shrt (.clk(clk), .rst(rst), .din(s.shrt), .dout(shrt_ok));
    prot_hold #(.LEN(INHIBIT))    u_inh  (.clk(clk), .rst(rst), .din(run), .dout(armed));
    prot_hold #(.LEN(BLANK))      u_blk  (.clk(clk), .rst(rst), .din(run & s.ssd & s.fbh),
                                          .dout(bl_release_o));
    prot_hold #(.LEN(LONG_FILT))  u_blp  (.clk(clk), .rst(rst), .din(s.blthr & bl_release_o),
                                          .dout(bl_ok));

    assign latch_req = ovp_ok | otp_ok | shrt_ok | (s.ext & armed);
    assign auto_req  = s.uvlo | bl_ok;

    prot_fsm u_fsm (
        .clk(clk), .rst(rst), .pdr(s.pdr), .vcc_on(s.vcc_on),
        .latch_req(latch_req), .auto_req(auto_req), .state(state)
    );

    assign gate_off_o = !gate_allowed(state);
    assign latched_o  = (state == ST_LATCH);
    assign autorst_o  = (state == ST_AUTO);

    assert_gate_forced_R13: assert property (@(posedge clk) disable iff (rst)
        (latched_o || autorst_o) |-> gate_off_o);

    assert_status_excl_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({latched_o, autorst_o}));

    assert_release_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(bl_release_o) |-> $past(s.fbh && s.ssd));

    assert_auto_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(autorst_o) |-> $past(s.uvlo || bl_ok));
endmodule

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;
    logic clk = 0, rst = 1;
    logic pdr_i = 0, vcc_on_i = 0, uvlo_i = 0, softstart_done_i = 0;
    logic ovp_i = 0, fb_high_i = 0, otp_i = 0, short_i = 0, ext_latch_i = 0, bl_thr_i = 0;
    logic gate_off_o, latched_o, autorst_o, bl_release_o;
    int   checks = 0, errors = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    prot_supervisor u0 (.*);

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        {pdr_i, vcc_on_i, uvlo_i, softstart_done_i, ovp_i, fb_high_i} = '0;
        {otp_i, short_i, ext_latch_i, bl_thr_i} = '0;
        rst = 1; tick(3); rst = 0; tick(1);
    endtask

    task automatic start();
        vcc_on_i = 1; tick(5); vcc_on_i = 0; tick(1);
    endtask

    task automatic t_reset_R1();
        do_reset();
        check(gate_off_o, 1, "R1 gate_off");
        check(latched_o, 0, "R1 latched");
        check(autorst_o, 0, "R1 autorst");
        check(bl_release_o, 0, "R1 release");
    endtask

    task automatic t_start_R2();
        do_reset(); start();
        check(gate_off_o, 0, "R2 gate enabled");
    endtask

    task automatic t_ovp_R3();
        do_reset(); start();
        ovp_i = 1; tick(30);
        check(latched_o, 0, "R3 ovp without fb");
        fb_high_i = 1; tick(30);
        check(latched_o, 1, "R3 ovp with fb");
        check(gate_off_o, 1, "R3 gate off");
    endtask

    task automatic t_otp_R4();
        do_reset(); start();
        otp_i = 1; tick(5); otp_i = 0; tick(20);
        check(latched_o, 0, "R4 short otp pulse");
        otp_i = 1; tick(20);
        check(latched_o, 1, "R4 otp held");
    endtask

    task automatic t_short_R5();
        do_reset(); start();
        short_i = 1; tick(1); short_i = 0; tick(10);
        check(latched_o, 0, "R5 one-cycle pulse");
        short_i = 1; tick(8);
        check(latched_o, 1, "R5 short held");
    endtask

    task automatic t_ext_R6();
        do_reset(); start();
        ext_latch_i = 1; tick(40); ext_latch_i = 0; tick(3);
        check(latched_o, 0, "R6 ext inside inhibit");
        tick(100);
        ext_latch_i = 1; tick(5);
        check(latched_o, 1, "R6 ext after inhibit");
    endtask

    task automatic t_latch_hold_R7();
        do_reset(); start();
        otp_i = 1; tick(20); otp_i = 0;
        vcc_on_i = 1; uvlo_i = 1; tick(10); uvlo_i = 0; tick(10); vcc_on_i = 0;
        check(latched_o, 1, "R7 held through supply cycling");
        check(gate_off_o, 1, "R7 gate off");
        pdr_i = 1; tick(4); pdr_i = 0; tick(2);
        check(latched_o, 0, "R7 cleared by pdr");
        check(gate_off_o, 1, "R7 waiting after pdr");
    endtask

    task automatic t_overload_R8_R9_R11();
        do_reset(); start();
        fb_high_i = 1; tick(300);
        check(bl_release_o, 0, "R8 frozen in soft start");
        softstart_done_i = 1; tick(150);
        check(bl_release_o, 0, "R8 before blank end");
        tick(70);
        check(bl_release_o, 1, "R8 release after blank");
        check(autorst_o, 0, "R9 no auto before pin trip");
        bl_thr_i = 1; tick(4); bl_thr_i = 0; tick(15);
        check(autorst_o, 0, "R9 short pin pulse");
        bl_thr_i = 1; tick(15);
        check(autorst_o, 1, "R9 auto after pin filter");
        check(gate_off_o, 1, "R9 gate off");
        bl_thr_i = 0; fb_high_i = 0; tick(20);
        check(autorst_o, 1, "R11 stays until restart");
        vcc_on_i = 1; tick(5); vcc_on_i = 0; tick(1);
        check(autorst_o, 0, "R11 restart leaves auto");
        check(gate_off_o, 0, "R11 running again");
    endtask

    task automatic t_uvlo_R10();
        do_reset(); start();
        uvlo_i = 1; tick(4); uvlo_i = 0; tick(2);
        check(autorst_o, 1, "R10 uvlo auto-restart");
        check(latched_o, 0, "R10 not latched");
    endtask

    task automatic t_priority_R12();
        do_reset(); start(); tick(110);
        ext_latch_i = 1; uvlo_i = 1; tick(5);
        check(latched_o, 1, "R12 latch wins");
        check(autorst_o, 0, "R12 no auto");
    endtask

    initial begin
        t_reset_R1();
        t_start_R2();
        t_ovp_R3();
        t_otp_R4();
        t_short_R5();
        t_ext_R6();
        t_latch_hold_R7();
        t_overload_R8_R9_R11();
        t_uvlo_R10();
        t_priority_R12();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule